// File: doc/BRIEF.md
# Multiplexed Boot ROM Bus Controller

This block reaches a byte-wide boot ROM over eight shared pad lines. Those lines carry, in turn, the ROM address, the ROM control strobes and the data. A request gives a 16-bit byte address, a read/write flag and a beat count. After the request is accepted the block drives two fixed address cycles. The first cycle carries the middle address bits and the two active-low ROM controls. The second carries the upper address byte. A one-hot pair of latch strobes tells external latches which cycle to capture. The data beats follow directly, one byte per clock. The two lowest address bits are not sent on the pads. They come out on a separate pair of lines and step through the four byte lanes of the word.

For reads the pads are released during the data beats. Each byte is captured and returned one cycle later with a valid strobe. For writes the block drives the pads from the write-data input and pulses an acknowledge for each byte it consumes. A single-cycle completion pulse marks the end of the burst. The block is idle with the pads released from that same cycle.

Top module: `bootrom_mux_ctrl`

## Requirements
- R1: After reset and whenever idle: busy=0, pad_oe=0, ale=2'b00, wr_take=0, done=0 and rd_valid=0.
- R2: In the cycle after a request is accepted (req_start high while idle), pad_oe=1, ale=2'b01 and pad_o = {addr[7:2], oe_n, we_n}. oe_n sits at bit 1 and we_n at bit 0, both active low: a read gives oe_n=0, we_n=1; a write gives oe_n=1, we_n=0.
- R3: The cycle after the first address cycle is always the second address cycle: pad_oe=1, ale=2'b10, pad_o = addr[15:8].
- R4: Exactly req_len+1 data beats follow the second address cycle back to back, with ale=2'b00 and busy=1 in each beat.
- R5: In data beat k (counting from 0), rom_a_lo = (addr[1:0] + k) mod 4.
- R6: During read beats pad_oe=0. The byte on pad_i in beat k appears on rd_data with rd_valid=1 in the next cycle, giving exactly req_len+1 valid pulses.
- R7: During write beats pad_oe=1, pad_o equals wr_data and wr_take=1. rd_valid stays 0.
- R8: done is a one-cycle pulse in the cycle after the last beat. In that cycle busy=0 and pad_oe=0.
- R9: req_start asserted while busy is ignored. The running access keeps its address, direction and length, and no second access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 16 | ROM byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | BEAT_W | Number of data beats minus one |
| wr_data | input | 8 | Byte put on the pads in a write beat |
| pad_i | input | 8 | Pad input value |
| pad_o | output | 8 | Pad output value |
| pad_oe | output | 1 | Pad driver enable (0 = released) |
| ale | output | 2 | One-hot latch strobes, bit 0 first address cycle, bit 1 second |
| rom_a_lo | output | 2 | ROM address bits 1:0 during data beats |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | rd_data valid |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |

## Verification
The assertions check on every cycle that the latch strobes stay one-hot and that the second address cycle always follows the first. They also check that the beat counter never passes the captured length, that the pads are released during read beats and while idle, and that captured request fields stay put while busy. Only the bench scenarios can show what the pads carry in each cycle. That covers the exact address and control bit packing, the lane sequence including wrap past lane 3, and the byte-for-byte return of read data one cycle late. It also covers write bytes reaching the pads and a stray request during an access leaving that access unchanged.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int PAD_W  = 8;
  localparam int ROM_AW = 16;
  localparam int LANE_W = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_AD1, PH_AD2, PH_DATA} brc_phase_e;

  // byte lane for a beat: low address bits advance and wrap inside the word
  function automatic logic [LANE_W-1:0] lane_of(logic [LANE_W-1:0] base,
                                                logic [LANE_W-1:0] beat);
    return base + beat;
  endfunction

  // first address cycle: addr[7:2], output enable (low = read), write enable (low = write)
  function automatic logic [PAD_W-1:0] ad1_word(logic [ROM_AW-1:0] a, logic wr);
    return {a[7:2], wr, ~wr};
  endfunction

  function automatic logic [PAD_W-1:0] ad2_word(logic [ROM_AW-1:0] a);
    return a[15:8];
  endfunction
endpackage

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ROM_AW-1:0] req_addr,
  input  logic              req_write,
  input  logic [BEAT_W-1:0] req_len,
  output brc_phase_e        phase,
  output logic [ROM_AW-1:0] addr_q,
  output logic              wr_q,
  output logic [BEAT_W-1:0] beat,
  output logic              last_beat,
  output logic              accept,
  output logic              done
);
  logic [BEAT_W-1:0] len_q;

  assign accept    = (phase == PH_IDLE) && req_start;
  assign last_beat = (phase == PH_DATA) && (beat == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      len_q  <= '0;
      beat   <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_beat;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_AD1;
          addr_q <= req_addr;
          wr_q   <= req_write;
          len_q  <= req_len;
        end
        PH_AD1: phase <= PH_AD2;
        PH_AD2: begin
          phase <= PH_DATA;
          beat  <= '0;
        end
        PH_DATA: begin
          if (last_beat) phase <= PH_IDLE;
          else           beat  <= beat + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_ad2_after_ad1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_AD1 |=> phase == PH_AD2);

  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DATA |-> beat <= len_q);

  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_IDLE |=> $stable(addr_q) && $stable(wr_q) && $stable(len_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/brc_padmux.sv
module brc_padmux
  import brc_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brc_phase_e        phase,
  input  logic [ROM_AW-1:0] addr_q,
  input  logic              wr_q,
  input  logic [BEAT_W-1:0] beat,
  input  logic [PAD_W-1:0]  wr_data,
  output logic [PAD_W-1:0]  pad_o,
  output logic              pad_oe,
  output logic [1:0]        ale,
  output logic [LANE_W-1:0] rom_a_lo,
  output logic              wr_take
);
  always_comb begin
    pad_o    = '0;
    pad_oe   = 1'b0;
    ale      = 2'b00;
    rom_a_lo = '0;
    wr_take  = 1'b0;
    unique case (phase)
      PH_AD1: begin
        pad_o  = ad1_word(addr_q, wr_q);
        pad_oe = 1'b1;
        ale    = 2'b01;
      end
      PH_AD2: begin
        pad_o  = ad2_word(addr_q);
        pad_oe = 1'b1;
        ale    = 2'b10;
      end
      PH_DATA: begin
        rom_a_lo = lane_of(addr_q[LANE_W-1:0], LANE_W'(beat));
        if (wr_q) begin
          pad_o   = wr_data;
          pad_oe  = 1'b1;
          wr_take = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assert_ale_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ale));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !wr_q) |-> !pad_oe);
endmodule

// File: rtl/bootrom_mux_ctrl.sv
module bootrom_mux_ctrl
  import brc_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ROM_AW-1:0] req_addr,
  input  logic              req_write,
  input  logic [BEAT_W-1:0] req_len,
  input  logic [PAD_W-1:0]  wr_data,
  input  logic [PAD_W-1:0]  pad_i,
  output logic [PAD_W-1:0]  pad_o,
  output logic              pad_oe,
  output logic [1:0]        ale,
  output logic [LANE_W-1:0] rom_a_lo,
  output logic              wr_take,
  output logic [PAD_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);
  brc_phase_e        phase;
  logic [ROM_AW-1:0] addr_q;
  logic              wr_q;
  logic [BEAT_W-1:0] beat;
  logic              last_beat;
  logic              accept;
  logic              rd_beat;

  brc_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_write(req_write), .req_len(req_len), .phase(phase), .addr_q(addr_q),
    .wr_q(wr_q), .beat(beat), .last_beat(last_beat), .accept(accept), .done(done)
  );

  brc_padmux #(.BEAT_W(BEAT_W)) u_pad (
    .clk(clk), .rst_n(rst_n), .phase(phase), .addr_q(addr_q), .wr_q(wr_q),
    .beat(beat), .wr_data(wr_data), .pad_o(pad_o), .pad_oe(pad_oe), .ale(ale),
    .rom_a_lo(rom_a_lo), .wr_take(wr_take)
  );

  assign busy    = (phase != PH_IDLE);
  assign rd_beat = (phase == PH_DATA) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_beat;
      if (rd_beat) rd_data <= pad_i;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pad_oe && ale == 2'b00 && !wr_take));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pad_oe));

  assert_accept_to_ad1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale == 2'b01);

  assert_last_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done);
endmodule

// File: tb/tb_bootrom_mux_ctrl.sv
module tb_bootrom_mux_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_len = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pad_i = '0;
  logic [7:0]  pad_o;
  logic        pad_oe;
  logic [1:0]  ale;
  logic [1:0]  rom_a_lo;
  logic        wr_take;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;

  bootrom_mux_ctrl #(.BEAT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_write(req_write), .req_len(req_len), .wr_data(wr_data), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .ale(ale), .rom_a_lo(rom_a_lo),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wpat(logic [15:0] a, int k);
    return 8'hC3 ^ a[7:0] ^ 8'(k * 37);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(pad_oe == 0, "R1 pad_oe", pad_oe, 0);
    chk(ale == 2'b00, "R1 ale", ale, 0);
    chk(done == 0 && rd_valid == 0 && wr_take == 0, "R1 strobes",
        {done, rd_valid, wr_take}, 0);
  endtask

  // runs one access starting at a negedge; stray=1 raises req_start while busy (R9)
  task automatic t_access(input logic [15:0] a, input bit wr, input logic [1:0] len,
                          input bit stray);
    int n = int'(len) + 1;
    req_addr = a; req_write = wr; req_len = len; req_start = 1'b1;
    @(negedge clk);
    if (stray) begin
      req_addr = ~a; req_write = ~wr; req_len = ~len;
    end else req_start = 1'b0;
    chk(ale == 2'b01, "R2 ale", ale, 1);
    chk(pad_oe == 1, "R2 pad_oe", pad_oe, 1);
    chk(pad_o == {a[7:2], wr, ~wr}, "R2 pad_o", pad_o, {a[7:2], wr, ~wr});
    @(negedge clk);
    chk(ale == 2'b10, "R3 ale", ale, 2);
    chk(pad_oe == 1 && pad_o == a[15:8], "R3 pad_o", pad_o, a[15:8]);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == n - 1) req_start = 1'b0;
      chk(busy == 1 && ale == 2'b00, "R4 beat busy/ale", {busy, ale}, 4);
      chk(rom_a_lo == 2'(int'(a[1:0]) + k), "R5 lane", rom_a_lo, 2'(int'(a[1:0]) + k));
      if (wr) begin
        wr_data = wpat(a, k);
        #1;
        chk(pad_oe == 1 && pad_o == wr_data, "R7 pad_o", pad_o, wr_data);
        chk(wr_take == 1 && rd_valid == 0, "R7 wr_take", {wr_take, rd_valid}, 2);
      end else begin
        pad_i = rom_byte({a[15:2], 2'(int'(a[1:0]) + k)});
        chk(pad_oe == 0, "R6 released", pad_oe, 0);
        if (k > 0) begin
          logic [7:0] e = rom_byte({a[15:2], 2'(int'(a[1:0]) + k - 1)});
          chk(rd_valid == 1 && rd_data == e, "R6 rd_data", rd_data, e);
        end
      end
    end
    @(negedge clk);
    chk(done == 1 && busy == 0 && pad_oe == 0, "R8 done", {done, busy, pad_oe}, 4);
    if (!wr) begin
      logic [7:0] e = rom_byte({a[15:2], 2'(int'(a[1:0]) + n - 1)});
      chk(rd_valid == 1 && rd_data == e, "R6 last rd_data", rd_data, e);
    end else chk(rd_valid == 0, "R7 no rd_valid", rd_valid, 0);
    @(negedge clk);
    chk(done == 0 && rd_valid == 0, "R8 single pulse", {done, rd_valid}, 0);
    chk(busy == 0 && ale == 2'b00, "R9/R1 idle after", {busy, ale}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_access(16'hA5F0, 1'b0, 2'd3, 1'b0);   // read, 4 beats from lane 0
    t_access(16'h3C6E, 1'b0, 2'd3, 1'b0);   // read, lane wraps 2,3,0,1
    t_access(16'h1237, 1'b0, 2'd0, 1'b0);   // single beat read
    t_access(16'hBEEF, 1'b1, 2'd2, 1'b0);   // write, 3 beats
    t_access(16'h0001, 1'b1, 2'd0, 1'b0);   // single beat write
    t_access(16'h4D29, 1'b0, 2'd1, 1'b1);   // R9 stray request while busy
    t_reset();
    summary();
  end
endmodule